// File: doc/BRIEF.md
# Pair-wise temporal correlation prefetcher

This block learns which cache-miss line address tends to follow which, and replays that history as prefetch requests. Misses arrive one line address at a time on a valid/ready input. Each accepted miss is first recorded as a successor of the miss before it. The block then looks itself up in a small direct-mapped correlation table. Each table entry is keyed by a line address (index from its low bits, with a stored tag for the rest) and keeps up to `BREADTH` successors, ordered from most recent to oldest.

When the lookup hits, every stored successor is offered on the prefetch output, most recent first. The walker then chains ahead. It takes the most recent successor, looks that address up, and offers only that entry's most recent successor, repeating until `DEPTH` levels have been produced or a lookup misses. Because the targets come from learned address pairs rather than arithmetic, linked structures with no stride can be prefetched. The miss input is held off, with ready low, from the cycle a miss is accepted until its whole walk has drained through the prefetch handshake.

Top module: `markov_prefetcher`

## Requirements
- R1: After reset `miss_ready` is 1, `pf_valid` is 0 and the table is empty, so early misses produce no prefetch.
- R2: If miss Y was accepted right after miss X, a later miss to X offers Y on the prefetch output. When the lookup hits, the first candidate is valid in the cycle right after the miss is accepted.
- R3: An entry holds up to `BREADTH` distinct successors. On a hit they are all offered in order from most recent to least recent.
- R4: Training with a successor already held in the entry moves it to the most-recent position. The successor is not duplicated and the entry's count does not change.
- R5: Training a new successor into a full entry drops the least recent one.
- R6: The table index is the low `IDX_W` bits of the line address and the rest is the tag. Training with a tag mismatch replaces the entry with a single successor, and a lookup whose tag mismatches offers nothing.
- R7: After the first level, the walker follows the most recent successor. For up to `DEPTH`-1 further levels it offers only that entry's most recent successor, and it stops early on a table miss.
- R8: From acceptance until its walk ends, `miss_ready` is 0. A miss presented during that time is not accepted and does not train the table. `pf_valid` is never 1 while `miss_ready` is 1.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` stays unchanged.
- R10: Training for a miss is applied before that same miss is looked up, so a repeated address (D then D) offers D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss line address is presented |
| miss_ready | output | 1 | The block can accept a miss this cycle |
| miss_addr | input | ADDR_W | Miss line address |
| pf_valid | output | 1 | A prefetch candidate is presented |
| pf_ready | input | 1 | The consumer takes the candidate this cycle |
| pf_addr | output | ADDR_W | Prefetch candidate line address |

## Verification
Training of the current miss into the previous miss's entry and the lookup of the current miss fall on the same acceptance. They touch the same entry whenever the two addresses share an index, and a plain repeat of the same address is the sharpest case. Repeats, index-sharing pairs with different tags and random sequences over eight addresses provoke this overlap. Every walk is judged against a bench model that applies the training first and then derives the expected candidate list from the requirements. Prefetch backpressure is also stalled on alternate cycles, and a competing miss is held on the input during walks, to show that emission ordering and input blocking stay correct while training and lookup overlap.

// File: rtl/mkv_pkg.sv
package mkv_pkg;
  typedef enum logic [0:0] {
    WK_IDLE = 1'b0,
    WK_EMIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/mkv_table.sv
module mkv_table #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 2,
  parameter int BREADTH = 2,
  localparam int CNT_W  = $clog2(BREADTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_key,
  input  logic [ADDR_W-1:0]               wr_succ,
  input  logic [ADDR_W-1:0]               rd_key,
  output logic                            rd_hit,
  output logic [CNT_W-1:0]                rd_cnt,
  output logic [BREADTH-1:0][ADDR_W-1:0]  rd_succ
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  logic [ENTRIES-1:0]               vld_q;
  logic [TAG_W-1:0]                 tag_q  [ENTRIES];
  logic [CNT_W-1:0]                 cnt_q  [ENTRIES];
  logic [BREADTH-1:0][ADDR_W-1:0]   succ_q [ENTRIES];

  logic [IDX_W-1:0]                 w_idx;
  logic [TAG_W-1:0]                 w_tag;
  logic                             same;
  logic                             found;
  logic [CNT_W-1:0]                 fpos;
  logic [CNT_W-1:0]                 lim;
  logic [CNT_W-1:0]                 cur_cnt;
  logic [BREADTH-1:0][ADDR_W-1:0]   cur_succ;
  logic [BREADTH-1:0][ADDR_W-1:0]   new_succ;
  logic [CNT_W-1:0]                 new_cnt;
  logic [IDX_W-1:0]                 r_idx;

  // training: compute the updated entry for the written key
  always_comb begin
    w_idx    = wr_key[IDX_W-1:0];
    w_tag    = wr_key[ADDR_W-1:IDX_W];
    cur_cnt  = cnt_q[w_idx];
    cur_succ = succ_q[w_idx];
    same     = vld_q[w_idx] && (tag_q[w_idx] == w_tag);
    found    = 1'b0;
    fpos     = '0;
    for (int i = 0; i < BREADTH; i++) begin
      if (!found && (CNT_W'(i) < cur_cnt) && (cur_succ[i] == wr_succ)) begin
        found = 1'b1;
        fpos  = CNT_W'(i);
      end
    end
    if (!same)                           lim = '0;
    else if (found)                      lim = fpos;
    else if (cur_cnt == CNT_W'(BREADTH)) lim = CNT_W'(BREADTH - 1);
    else                                 lim = cur_cnt;
    new_succ    = cur_succ;
    new_succ[0] = wr_succ;
    for (int i = 1; i < BREADTH; i++) begin
      if (CNT_W'(i) <= lim) new_succ[i] = cur_succ[i-1];
    end
    if (!same)                                          new_cnt = CNT_W'(1);
    else if (found || (cur_cnt == CNT_W'(BREADTH)))     new_cnt = cur_cnt;
    else                                                new_cnt = cur_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q        <= '0;
    else if (wr_en) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[w_idx]  <= w_tag;
      cnt_q[w_idx]  <= new_cnt;
      succ_q[w_idx] <= new_succ;
    end
  end

  // lookup port
  always_comb begin
    r_idx   = rd_key[IDX_W-1:0];
    rd_hit  = vld_q[r_idx] && (tag_q[r_idx] == rd_key[ADDR_W-1:IDX_W]);
    rd_cnt  = cnt_q[r_idx];
    rd_succ = succ_q[r_idx];
  end
endmodule

// File: rtl/mkv_walker.sv
module mkv_walker
  import mkv_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BREADTH = 2,
  parameter int DEPTH   = 3,
  localparam int CNT_W  = $clog2(BREADTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            miss_valid,
  output logic                            miss_ready,
  input  logic [ADDR_W-1:0]               miss_addr,
  output logic                            pf_valid,
  input  logic                            pf_ready,
  output logic [ADDR_W-1:0]               pf_addr,
  output logic                            tr_en,
  output logic [ADDR_W-1:0]               tr_key,
  output logic [ADDR_W-1:0]               tr_succ,
  output logic [ADDR_W-1:0]               lk_key,
  input  logic                            lk_hit,
  input  logic [CNT_W-1:0]                lk_cnt,
  input  logic [BREADTH-1:0][ADDR_W-1:0]  lk_succ
);
  localparam int LVL_W  = (DEPTH > 1)   ? $clog2(DEPTH)   : 1;
  localparam int SLOT_W = (BREADTH > 1) ? $clog2(BREADTH) : 1;

  walk_state_e         state_q, state_d;
  logic [ADDR_W-1:0]   look_q, look_d;
  logic [ADDR_W-1:0]   prev_q, prev_d;
  logic                prevv_q, prevv_d;
  logic [LVL_W-1:0]    lvl_q, lvl_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic                accept;
  logic                last_slot;
  logic                last_lvl;

  always_comb begin
    miss_ready = (state_q == WK_IDLE);
    accept     = miss_valid && miss_ready;
    tr_en      = accept && prevv_q;
    tr_key     = prev_q;
    tr_succ    = miss_addr;
    lk_key     = look_q;
    pf_valid   = (state_q == WK_EMIT) && lk_hit;
    pf_addr    = lk_succ[slot_q];
    last_slot  = (lvl_q != '0) || ((CNT_W'(slot_q) + CNT_W'(1)) == lk_cnt);
    last_lvl   = (lvl_q == LVL_W'(DEPTH - 1));

    state_d = state_q;
    look_d  = look_q;
    prev_d  = prev_q;
    prevv_d = prevv_q;
    lvl_d   = lvl_q;
    slot_d  = slot_q;
    case (state_q)
      WK_IDLE: begin
        if (accept) begin
          state_d = WK_EMIT;
          look_d  = miss_addr;
          prev_d  = miss_addr;
          prevv_d = 1'b1;
          lvl_d   = '0;
          slot_d  = '0;
        end
      end
      default: begin
        if (!lk_hit) begin
          state_d = WK_IDLE;
        end else if (pf_ready) begin
          if (!last_slot) begin
            slot_d = slot_q + 1'b1;
          end else if (last_lvl) begin
            state_d = WK_IDLE;
          end else begin
            look_d = lk_succ[0];
            lvl_d  = lvl_q + 1'b1;
            slot_d = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      look_q  <= '0;
      prev_q  <= '0;
      prevv_q <= 1'b0;
      lvl_q   <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      look_q  <= look_d;
      prev_q  <= prev_d;
      prevv_q <= prevv_d;
      lvl_q   <= lvl_d;
      slot_q  <= slot_d;
    end
  end
endmodule

// File: rtl/markov_prefetcher.sv
module markov_prefetcher #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 2,
  parameter int BREADTH = 2,
  parameter int DEPTH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int CNT_W = $clog2(BREADTH + 1);

  logic                            tr_en;
  logic [ADDR_W-1:0]               tr_key;
  logic [ADDR_W-1:0]               tr_succ;
  logic [ADDR_W-1:0]               lk_key;
  logic                            lk_hit;
  logic [CNT_W-1:0]                lk_cnt;
  logic [BREADTH-1:0][ADDR_W-1:0]  lk_succ;

  mkv_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BREADTH(BREADTH)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tr_en),
    .wr_key  (tr_key),
    .wr_succ (tr_succ),
    .rd_key  (lk_key),
    .rd_hit  (lk_hit),
    .rd_cnt  (lk_cnt),
    .rd_succ (lk_succ)
  );

  mkv_walker #(.ADDR_W(ADDR_W), .BREADTH(BREADTH), .DEPTH(DEPTH)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .miss_addr  (miss_addr),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .tr_en      (tr_en),
    .tr_key     (tr_key),
    .tr_succ    (tr_succ),
    .lk_key     (lk_key),
    .lk_hit     (lk_hit),
    .lk_cnt     (lk_cnt),
    .lk_succ    (lk_succ)
  );
endmodule

// File: rtl/mkv_checker.sv
module mkv_checker #(
  parameter int ADDR_W  = 16,
  parameter int BREADTH = 2,
  parameter int DEPTH   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  logic [7:0] emitted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      emitted_q <= '0;
    else if (miss_valid && miss_ready) emitted_q <= '0;
    else if (pf_valid && pf_ready)   emitted_q <= emitted_q + 1'b1;
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !miss_ready); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready); // R8
  AST_PF_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> pf_valid); // R9
  AST_PF_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> $stable(pf_addr)); // R9
  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (emitted_q < 8'(BREADTH + DEPTH - 1))); // R7
endmodule

bind markov_prefetcher mkv_checker #(.ADDR_W(ADDR_W), .BREADTH(BREADTH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .miss_addr  (miss_addr),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_addr    (pf_addr)
);

// File: tb/tb_markov_prefetcher.sv
`timescale 1ns/1ps
module tb_markov_prefetcher;
  localparam int AW = 16;
  localparam int IW = 2;
  localparam int B  = 2;
  localparam int D  = 3;
  localparam int NE = 1 << IW;

  logic          clk;
  logic          rst_n;
  logic          miss_valid;
  logic          miss_ready;
  logic [AW-1:0] miss_addr;
  logic          pf_valid;
  logic          pf_ready;
  logic [AW-1:0] pf_addr;

  markov_prefetcher #(.ADDR_W(AW), .IDX_W(IW), .BREADTH(B), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model of the table
  bit            mv [NE];
  logic [AW-1:0] mk [NE];
  int            mc [NE];
  logic [AW-1:0] ms [NE][B];
  bit            have_prev;
  logic [AW-1:0] prev_a;
  logic [AW-1:0] expv [8];
  int            nexp;
  bit            stall;
  bit            hold_other;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ix(input logic [AW-1:0] a);
    return int'(a % NE);
  endfunction

  function automatic bit mhit(input logic [AW-1:0] a);
    return mv[ix(a)] && (mk[ix(a)] == a);
  endfunction

  task automatic mtrain(input logic [AW-1:0] key, input logic [AW-1:0] s);
    int e = ix(key);
    int p = -1;
    if (!mhit(key)) begin
      mv[e] = 1'b1; mk[e] = key; mc[e] = 1; ms[e][0] = s;
    end else begin
      for (int i = 0; i < mc[e]; i++) if (ms[e][i] == s && p < 0) p = i;
      if (p < 0) begin
        p = (mc[e] < B) ? mc[e] : B - 1;
        if (mc[e] < B) mc[e]++;
      end
      for (int i = p; i >= 1; i--) ms[e][i] = ms[e][i-1];
      ms[e][0] = s;
    end
  endtask

  task automatic mexpect(input logic [AW-1:0] a);
    logic [AW-1:0] l;
    nexp = 0;
    if (mhit(a)) begin
      for (int i = 0; i < mc[ix(a)]; i++) begin expv[nexp] = ms[ix(a)][i]; nexp++; end
      l = ms[ix(a)][0];
      for (int lv = 1; lv < D; lv++) begin
        if (!mhit(l)) break;
        l = ms[ix(l)][0];
        expv[nexp] = l; nexp++;
      end
    end
  endtask

  task automatic do_miss(input logic [AW-1:0] a, input string tag);
    logic [AW-1:0] got [8];
    logic [AW-1:0] held;
    bit hf = 1'b0;
    bit first = 1'b1;
    int n = 0;
    int cyc = 0;
    if (have_prev) mtrain(prev_a, a);
    have_prev = 1'b1;
    prev_a = a;
    mexpect(a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = hold_other;
    miss_addr  = a ^ 16'h0100;
    while (!miss_ready) begin
      if (first) chk(pf_valid == (nexp > 0), {tag, " first-cycle"}, 32'(pf_valid), 32'(nexp > 0));
      first = 1'b0;
      if (pf_valid && pf_ready) begin
        if (n < 8) got[n] = pf_addr;
        n++;
      end else if (pf_valid) begin
        held = pf_addr; hf = 1'b1;
      end
      @(negedge clk);
      if (hf) begin
        chk(pf_valid && (pf_addr == held), "R9 hold", 32'(pf_addr), 32'(held));
        hf = 1'b0;
      end
      pf_ready = !stall || cyc[0];
      cyc++;
    end
    miss_valid = 1'b0;
    pf_ready   = 1'b1;
    chk(n == nexp, {tag, " count"}, 32'(n), 32'(nexp));
    for (int i = 0; i < n && i < nexp && i < 8; i++)
      chk(got[i] == expv[i], {tag, " addr"}, 32'(got[i]), 32'(expv[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [8];
    for (int k = 0; k < 8; k++) pool[k] = {4'h0, (k >= 4) ? 4'h5 : 4'h9, 6'h00, 2'(k)};
    for (int e = 0; e < NE; e++) mv[e] = 1'b0;
    have_prev = 1'b0; stall = 1'b0; hold_other = 1'b0;
    miss_valid = 1'b0; miss_addr = '0; pf_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1 ready", 32'(miss_ready), 32'd1);
    chk(pf_valid == 1'b0, "R1 pfvalid", 32'(pf_valid), 32'd0);
    do_miss(16'h0010, "R1");
    do_miss(16'h0021, "R1");
    // linked list with no stride
    for (int r = 0; r < 2; r++) begin
      do_miss(16'h0100, "R2"); do_miss(16'h0205, "R2");
      do_miss(16'h030A, "R2"); do_miss(16'h040F, "R2");
    end
    // breadth and ordering
    do_miss(16'h0A03, "R3"); do_miss(16'h0B00, "R3");
    do_miss(16'h0A03, "R3"); do_miss(16'h0C01, "R3");
    do_miss(16'h0A03, "R3");
    // duplicate promotion
    do_miss(16'h0B00, "R4"); do_miss(16'h0A03, "R4");
    do_miss(16'h0A03, "R4");
    // eviction of the oldest
    do_miss(16'h0D02, "R5"); do_miss(16'h0A03, "R5");
    do_miss(16'h0E02, "R5"); do_miss(16'h0A03, "R5");
    // tag conflict on shared index
    do_miss(16'h0100, "R6"); do_miss(16'h0111, "R6");
    do_miss(16'h0500, "R6"); do_miss(16'h0111, "R6");
    do_miss(16'h0100, "R6"); do_miss(16'h0500, "R6");
    // same address back to back
    do_miss(16'h0222, "R10"); do_miss(16'h0222, "R10");
    do_miss(16'h0222, "R10");
    // chain and backpressure
    stall = 1'b1;
    for (int r = 0; r < 3; r++) begin
      do_miss(16'h0301, "R7"); do_miss(16'h0402, "R7");
      do_miss(16'h0503, "R7"); do_miss(16'h0600, "R7");
    end
    // competing miss held during walks must be ignored
    hold_other = 1'b1;
    for (int r = 0; r < 40; r++) do_miss(pool[r % 5], "R8");
    hold_other = 1'b0;
    for (int r = 0; r < 400; r++) begin
      stall = r[3];
      do_miss(pool[$urandom_range(0, 7)], "R7 sweep");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule